// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is a single timer channel built around two 16-bit up-counters, A and B, that advance on a shared count tick. Either counter can be told to wrap back to zero at a cycle value supplied from outside the channel, instead of running through its full range. Each counter flags an overflow when it rolls past its top value.

Eight 16-bit slot registers are each tied to one pin. A slot can be left idle, set to capture, or set to compare. In capture mode, a chosen edge on the slot's input pin stores counter A into the slot. In compare mode, the slot is matched against counter A on each tick, and a match drives, clears or toggles the slot's output pin. A ninth, dedicated register stores counter A on a rising edge of a separate twin-capture trigger. Every event raises a sticky interrupt flag, and software clears the flags by writing ones.

Software uses a plain single-cycle register port. A write takes effect on the clock edge where `wr_en` is high. A read is combinational from `rd_addr`. The port has no handshake, so there is no back-pressure. The only data paths in the block are this port and the pins, and none of them is a stream, so the block has no valid/ready interface.

Top module: `cct_timer_chan`

## Requirements
- R1: After reset, both counters, all slot registers, all configuration fields, the twin register, all flags and `pin_out` are zero.
- R2: On each clock edge with `cnt_tick` high, each counter advances by one. Without a tick, each counter holds its value. Counters A and B are independent, and software can load either one (A at address 16, B at address 17), with the load taking priority over the tick.
- R3: A tick that moves a counter from 0xFFFF to 0x0000 sets its overflow flag: flag bit 8 for A and bit 9 for B. `irq_ovf` shows those two bits.
- R4: When `cyc_sel_a` (or `cyc_sel_b`) is high and the counter equals `cyc_val` on a tick, the counter goes to zero on that edge. This wrap sets no overflow flag, even when `cyc_val` is 0xFFFF.
- R5: Slot i is configured at address 8+i. Bits [1:0] hold the mode: 0 or 3 means idle, 1 means capture, 2 means compare. Bits [3:2] hold the action. In capture mode, action 0 captures on a rising edge, action 1 on a falling edge, and action 2 or 3 on both edges. A capture stores counter A into the slot register at address i and sets flag bit i.
- R6: Each pin passes through a two-flop synchronizer. A pin change that is sampled at edge k is captured at edge k+2, so the slot still holds its old value after edge k+1.
- R7: In compare mode, a tick on which counter A equals the slot value sets flag bit i on that edge. It also updates `pin_out[i]` according to the action: 0 drives 0, 1 drives 1, 2 toggles, and 3 leaves the pin unchanged.
- R8: A compare match is evaluated only on ticks. When counter A equals the slot value and no tick occurs, neither the pin nor the flag changes.
- R9: The flag register is at address 19, with bit i for slot i, bits 8 and 9 for overflow and bit 10 for twin capture. Writing 1 to a bit clears it, but an event in the same cycle leaves the bit set. `irq_evt`, `irq_ovf` and `irq_twin` show the flags.
- R10: When a capture and a software write to the same slot register fall in the same cycle, the captured counter value is stored. A write without a capture stores the written data.
- R11: A rising edge on `twin_trig`, after the same two-flop synchronization, stores counter A into the twin register (address 18, read-only) and sets flag bit 10. The slot registers are not changed, and a falling edge does nothing.
- R12: An idle slot ignores edges on its input pin and compare values. Its register, its flag and its pin stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_tick | input | 1 | Count enable for both counters |
| cyc_sel_a | input | 1 | Counter A wraps at `cyc_val` |
| cyc_sel_b | input | 1 | Counter B wraps at `cyc_val` |
| cyc_val | input | 16 | Externally supplied cycle value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| pin_in | input | 8 | Capture inputs, one per slot |
| pin_out | output | 8 | Compare outputs, one per slot |
| twin_trig | input | 1 | Twin-capture trigger |
| irq_evt | output | 8 | Per-slot capture/compare flags |
| irq_ovf | output | 2 | Overflow flags for counters B and A |
| irq_twin | output | 1 | Twin-capture flag |

## Verification
The hardest cases to reach are the two same-cycle collisions. One is a capture landing in the cycle of a software write to the same slot. The other is an event landing in the cycle of its own flag-clear write. The bench holds the tick low so that counter A is frozen, then counts the synchronizer stages: it asserts the slot write exactly two edges after the pin change, which is the edge where the capture commits. For the flag collision, it raises the tick with counter A preset to the compare value in the same cycle as the clear write. Compare actions are checked in an order that leaves the pin at the level each action would visibly change.

// File: rtl/cct_pkg.sv
package cct_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_CAP  = 2'd1,
    MODE_CMP  = 2'd2,
    MODE_RSVD = 2'd3
  } slot_mode_e;

  typedef struct packed {
    logic [1:0] act;
    slot_mode_e mode;
  } slot_cfg_t;

  localparam int unsigned CFG_W = $bits(slot_cfg_t);

  // compare actions
  localparam logic [1:0] ACT_LOW  = 2'd0;
  localparam logic [1:0] ACT_HIGH = 2'd1;
  localparam logic [1:0] ACT_TGL  = 2'd2;

  // capture edge selection
  localparam logic [1:0] EDGE_RISE = 2'd0;
  localparam logic [1:0] EDGE_FALL = 2'd1;

endpackage

// File: rtl/cct_edge_sync.sv
module cct_edge_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;

endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wrap_en,
  input  logic [CW-1:0] wrap_val,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          ovf
);

  logic at_wrap;

  assign at_wrap = wrap_en && (cnt == wrap_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick) begin
      cnt <= at_wrap ? '0 : cnt + 1'b1;
    end
  end

  // overflow only on a natural roll-over, never on a cycle wrap
  assign ovf = tick && !load && !at_wrap && (cnt == '1);

endmodule

// File: rtl/cct_slot.sv
module cct_slot
  import cct_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  slot_cfg_t     cfg,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic          pin_rise,
  input  logic          pin_fall,
  input  logic          tick,
  input  logic [CW-1:0] cnt,
  output logic [CW-1:0] gr,
  output logic          pin,
  output logic          ev
);

  logic cap_hit, cmp_hit, edge_ok;

  always_comb begin
    unique case (cfg.act)
      EDGE_RISE: edge_ok = pin_rise;
      EDGE_FALL: edge_ok = pin_fall;
      default:   edge_ok = pin_rise | pin_fall;
    endcase
  end

  assign cap_hit = (cfg.mode == MODE_CAP) && edge_ok;
  assign cmp_hit = (cfg.mode == MODE_CMP) && tick && (cnt == gr);
  assign ev      = cap_hit | cmp_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gr <= '0;
    end else if (cap_hit) begin
      gr <= cnt;
    end else if (wr) begin
      gr <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin <= 1'b0;
    end else if (cmp_hit) begin
      unique case (cfg.act)
        ACT_LOW:  pin <= 1'b0;
        ACT_HIGH: pin <= 1'b1;
        ACT_TGL:  pin <= ~pin;
        default:  pin <= pin;
      endcase
    end
  end

endmodule

// File: rtl/cct_timer_chan.sv
module cct_timer_chan
  import cct_pkg::*;
#(
  parameter int CW   = 16,
  parameter int NREG = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cnt_tick,
  input  logic                          cyc_sel_a,
  input  logic                          cyc_sel_b,
  input  logic [CW-1:0]                 cyc_val,
  input  logic                          wr_en,
  input  logic [$clog2(2*NREG+4)-1:0]   wr_addr,
  input  logic [CW-1:0]                 wr_data,
  input  logic [$clog2(2*NREG+4)-1:0]   rd_addr,
  output logic [CW-1:0]                 rd_data,
  input  logic [NREG-1:0]               pin_in,
  output logic [NREG-1:0]               pin_out,
  input  logic                          twin_trig,
  output logic [NREG-1:0]               irq_evt,
  output logic [1:0]                    irq_ovf,
  output logic                          irq_twin
);

  localparam int AW = $clog2(2*NREG+4);
  localparam int FW = NREG + 3;
  localparam logic [AW-1:0] ADR_CNTA  = AW'(2*NREG);
  localparam logic [AW-1:0] ADR_CNTB  = AW'(2*NREG+1);
  localparam logic [AW-1:0] ADR_TWIN  = AW'(2*NREG+2);
  localparam logic [AW-1:0] ADR_FLAGS = AW'(2*NREG+3);

  logic [CW-1:0]   cnt_a, cnt_b, twin_q;
  logic            ovf_a, ovf_b, wr_cnt_a, wr_cnt_b, wr_flags;
  logic [NREG-1:0] pin_rise, pin_fall, slot_ev;
  logic            twin_rise, twin_fall_unused;
  logic [FW-1:0]   flags_q, flag_set, flag_clr;
  logic [CW-1:0]   gr_q  [NREG];
  slot_cfg_t       cfg_q [NREG];

  assign wr_cnt_a = wr_en && (wr_addr == ADR_CNTA);
  assign wr_cnt_b = wr_en && (wr_addr == ADR_CNTB);
  assign wr_flags = wr_en && (wr_addr == ADR_FLAGS);

  cct_counter #(.CW(CW)) u_cnt_a (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .wrap_en(cyc_sel_a),
    .wrap_val(cyc_val), .load(wr_cnt_a), .load_val(wr_data),
    .cnt(cnt_a), .ovf(ovf_a)
  );

  cct_counter #(.CW(CW)) u_cnt_b (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .wrap_en(cyc_sel_b),
    .wrap_val(cyc_val), .load(wr_cnt_b), .load_val(wr_data),
    .cnt(cnt_b), .ovf(ovf_b)
  );

  cct_edge_sync #(.W(NREG)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .rise(pin_rise), .fall(pin_fall)
  );

  cct_edge_sync #(.W(1)) u_twin_sync (
    .clk(clk), .rst_n(rst_n), .din(twin_trig), .rise(twin_rise),
    .fall(twin_fall_unused)
  );

  for (genvar gi = 0; gi < NREG; gi++) begin : g_slot
    logic wr_gr, wr_cfg;
    assign wr_gr  = wr_en && (wr_addr == AW'(gi));
    assign wr_cfg = wr_en && (wr_addr == AW'(NREG + gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q[gi] <= '0;
      else if (wr_cfg) cfg_q[gi] <= slot_cfg_t'(wr_data[CFG_W-1:0]);
    end

    cct_slot #(.CW(CW)) u_slot (
      .clk(clk), .rst_n(rst_n), .cfg(cfg_q[gi]), .wr(wr_gr), .wdata(wr_data),
      .pin_rise(pin_rise[gi]), .pin_fall(pin_fall[gi]), .tick(cnt_tick),
      .cnt(cnt_a), .gr(gr_q[gi]), .pin(pin_out[gi]), .ev(slot_ev[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         twin_q <= '0;
    else if (twin_rise) twin_q <= cnt_a;
  end

  // sticky flags: an event in the clear cycle keeps the bit set
  assign flag_set = {twin_rise, ovf_b, ovf_a, slot_ev};
  assign flag_clr = wr_flags ? wr_data[FW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~flag_clr) | flag_set;
  end

  assign irq_evt  = flags_q[NREG-1:0];
  assign irq_ovf  = flags_q[NREG+1:NREG];
  assign irq_twin = flags_q[NREG+2];

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NREG; k++) begin
      if (rd_addr == AW'(k))        rd_data = gr_q[k];
      if (rd_addr == AW'(NREG + k)) rd_data = {{(CW-CFG_W){1'b0}}, cfg_q[k]};
    end
    if (rd_addr == ADR_CNTA)  rd_data = cnt_a;
    if (rd_addr == ADR_CNTB)  rd_data = cnt_b;
    if (rd_addr == ADR_TWIN)  rd_data = twin_q;
    if (rd_addr == ADR_FLAGS) rd_data = {{(CW-FW){1'b0}}, flags_q};
  end

endmodule

// File: rtl/cct_timer_chan_chk.sv
module cct_timer_chan_chk #(
  parameter int CW   = 16,
  parameter int NREG = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic            cyc_sel_a,
  input logic [CW-1:0]   cyc_val,
  input logic            wr_cnt_a,
  input logic [CW-1:0]   cnt_a,
  input logic            flag_ovf_a,
  input logic            flag_twin,
  input logic [NREG-1:0] flag_evt,
  input logic            twin_rise,
  input logic [CW-1:0]   twin_q,
  input logic [NREG-1:0] slot_ev,
  input logic [NREG-1:0] pin_out
);

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_cnt_a && !(cyc_sel_a && cnt_a == cyc_val)
    |=> cnt_a == $past(cnt_a) + 1'b1);

  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !wr_cnt_a |=> $stable(cnt_a));

  p_ovf_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_cnt_a && !(cyc_sel_a && cnt_a == cyc_val) && cnt_a == '1
    |=> flag_ovf_a);

  p_cyc_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_cnt_a && cyc_sel_a && cnt_a == cyc_val |=> cnt_a == '0);

  p_no_ovf_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_cnt_a && cyc_sel_a && cnt_a == cyc_val && !flag_ovf_a
    |=> !flag_ovf_a);

  p_pin_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    slot_ev == '0 |=> $stable(pin_out));

  p_evt_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_ev != '0 |=> (flag_evt & $past(slot_ev)) == $past(slot_ev));

  p_twin_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    twin_rise |=> twin_q == $past(cnt_a) && flag_twin);

endmodule

bind cct_timer_chan cct_timer_chan_chk #(.CW(CW), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .cyc_sel_a(cyc_sel_a),
  .cyc_val(cyc_val), .wr_cnt_a(wr_cnt_a), .cnt_a(cnt_a),
  .flag_ovf_a(flags_q[NREG]), .flag_twin(flags_q[NREG+2]),
  .flag_evt(flags_q[NREG-1:0]), .twin_rise(twin_rise), .twin_q(twin_q),
  .slot_ev(slot_ev), .pin_out(pin_out)
);

// File: tb/cct_timer_chan_tb_top.sv
`timescale 1ns/1ps
module cct_timer_chan_tb_top;

  localparam int SEL_PIN = 32, SEL_EVT = 33, SEL_OVF = 34, SEL_TWIN = 35;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_tick = 1'b0, cyc_sel_a = 1'b0, cyc_sel_b = 1'b0;
  logic [15:0] cyc_val = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic [7:0]  pin_in = '0, pin_out, irq_evt;
  logic [1:0]  irq_ovf;
  logic        twin_trig = 1'b0, irq_twin;

  always #5 clk = ~clk;

  cct_timer_chan dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cyc_sel_a(cyc_sel_a),
    .cyc_sel_b(cyc_sel_b), .cyc_val(cyc_val), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in),
    .pin_out(pin_out), .twin_trig(twin_trig), .irq_evt(irq_evt),
    .irq_ovf(irq_ovf), .irq_twin(irq_twin)
  );

  typedef struct {
    string       req;
    int          sel;
    logic [15:0] val;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0, n_bad = 0;
  bit   mon_busy = 1'b0, done = 1'b0;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      exp_t        it;
      logic [15:0] act;
      wait (exp_q.size() != 0);
      mon_busy = 1'b1;
      it = exp_q.pop_front();
      if (it.sel < 32) rd_addr = it.sel[4:0];
      #0.5;
      case (it.sel)
        SEL_PIN:  act = {8'h00, pin_out};
        SEL_EVT:  act = {8'h00, irq_evt};
        SEL_OVF:  act = {14'h0, irq_ovf};
        SEL_TWIN: act = {15'h0, irq_twin};
        default:  act = rd_data;
      endcase
      n_cmp++;
      if (act !== it.val) begin
        n_bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.val);
      end
      mon_busy = 1'b0;
    end
  end

  task automatic expect_val(input string req, input int sel, input logic [15:0] v);
    exp_q.push_back('{req, sel, v});
  endtask

  task automatic settle();
    wait (exp_q.size() == 0);
    wait (!mon_busy);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    expect_val("R1 cnt A", 16, 16'h0);
    expect_val("R1 cnt B", 17, 16'h0);
    expect_val("R1 flags", 19, 16'h0);
    expect_val("R1 pin_out", SEL_PIN, 16'h0);
    settle();

    // R2 counting, hold and independent load
    cnt_tick = 1'b1; step(5); cnt_tick = 1'b0;
    expect_val("R2 A after 5 ticks", 16, 16'd5);
    expect_val("R2 B after 5 ticks", 17, 16'd5);
    settle();
    wr(17, 16'd100);
    step(2);
    expect_val("R2 A held", 16, 16'd5);
    settle();
    cnt_tick = 1'b1; step(3); cnt_tick = 1'b0;
    expect_val("R2 A", 16, 16'd8);
    expect_val("R2 B loaded+3", 17, 16'd103);
    settle();

    // R3 overflow
    wr(16, 16'hFFFE);
    cnt_tick = 1'b1; step(2); cnt_tick = 1'b0;
    expect_val("R3 A wrapped", 16, 16'h0);
    expect_val("R3 flags ovfA", 19, 16'h0100);
    expect_val("R3 irq_ovf A", SEL_OVF, 16'h1);
    settle();
    wr(19, 16'h0100);
    expect_val("R9 W1C ovfA", 19, 16'h0);
    settle();
    wr(17, 16'hFFFF);
    cnt_tick = 1'b1; step(1); cnt_tick = 1'b0;
    expect_val("R3 B wrapped", 17, 16'h0);
    expect_val("R3 irq_ovf B", SEL_OVF, 16'h2);
    settle();
    wr(19, 16'h07FF);

    // R4 cycle wrap
    cyc_sel_a = 1'b1; cyc_val = 16'd3;
    wr(16, 16'h0);
    cnt_tick = 1'b1; step(5); cnt_tick = 1'b0;
    expect_val("R4 A wraps at 3", 16, 16'd1);
    expect_val("R4 no ovf", 19, 16'h0);
    settle();
    cyc_val = 16'hFFFF;
    wr(16, 16'hFFFF);
    cnt_tick = 1'b1; step(1); cnt_tick = 1'b0;
    expect_val("R4 wrap at FFFF", 16, 16'h0);
    expect_val("R4 no ovf at FFFF", 19, 16'h0);
    settle();
    cyc_sel_a = 1'b0;

    // R5 / R6 capture
    wr(8, 16'h1);   // slot0 capture rising
    wr(9, 16'h5);   // slot1 capture falling
    wr(10, 16'h9);  // slot2 capture both
    wr(16, 16'h1234);
    pin_in[0] = 1'b1;
    step(2);
    expect_val("R6 not yet captured", 0, 16'h0);
    settle();
    step(1);
    expect_val("R6 captured at k+2", 0, 16'h1234);
    expect_val("R5 flag slot0", 19, 16'h0001);
    settle();
    wr(16, 16'h2222);
    pin_in[0] = 1'b0;
    step(3);
    expect_val("R5 rising-only ignores fall", 0, 16'h1234);
    settle();
    pin_in[2:1] = 2'b11;
    step(3);
    expect_val("R5 falling-only ignores rise", 1, 16'h0);
    expect_val("R5 both edges rise", 2, 16'h2222);
    settle();
    wr(16, 16'h3333);
    pin_in[2:1] = 2'b00;
    step(3);
    expect_val("R5 falling capture", 1, 16'h3333);
    expect_val("R5 both edges fall", 2, 16'h3333);
    expect_val("R5 flags", 19, 16'h0007);
    settle();
    wr(19, 16'h07FF);

    // R12 idle slot
    pin_in[3] = 1'b1; step(3); pin_in[3] = 1'b0; step(3);
    expect_val("R12 idle reg", 3, 16'h0);
    expect_val("R12 idle flags", 19, 16'h0);
    settle();

    // R7 compare
    wr(4, 16'h0010);
    wr(5, 16'h0010);
    wr(12, 16'h6);  // slot4 compare drive 1
    wr(13, 16'hA);  // slot5 compare toggle
    wr(16, 16'h000E);
    cnt_tick = 1'b1; step(3); cnt_tick = 1'b0;
    expect_val("R7 set+toggle pins", SEL_PIN, 16'h0030);
    expect_val("R7 flags", 19, 16'h0030);
    settle();
    wr(19, 16'h07FF);
    // R8 equal without tick
    wr(16, 16'h0010);
    step(3);
    expect_val("R8 no tick pins", SEL_PIN, 16'h0030);
    expect_val("R8 no tick flags", 19, 16'h0);
    settle();
    wr(12, 16'h2);  // slot4 drive 0
    cnt_tick = 1'b1; step(1); cnt_tick = 1'b0;
    expect_val("R7 drive0 + toggle back", SEL_PIN, 16'h0000);
    settle();
    wr(19, 16'h07FF);
    wr(13, 16'hE);  // slot5 no pin change
    wr(16, 16'h0010);
    cnt_tick = 1'b1; step(1); cnt_tick = 1'b0;
    expect_val("R7 action3 keeps pin", SEL_PIN, 16'h0000);
    expect_val("R7 action3 flag", 19, 16'h0030);
    settle();
    wr(19, 16'h07FF);

    // R9 set beats clear
    wr(16, 16'h0010);
    cnt_tick = 1'b1; wr_en = 1'b1; wr_addr = 5'd19; wr_data = 16'h0010;
    step(1);
    wr_en = 1'b0; cnt_tick = 1'b0;
    expect_val("R9 set wins", 19, 16'h0030);
    expect_val("R9 irq_evt", SEL_EVT, 16'h0030);
    settle();
    wr(19, 16'h07FF);
    expect_val("R9 irq cleared", SEL_EVT, 16'h0);
    settle();

    // R10 capture beats write
    wr(16, 16'h0777);
    pin_in[0] = 1'b1;
    step(2);
    wr(5'd0, 16'hBEEF);
    expect_val("R10 capture wins", 0, 16'h0777);
    settle();
    wr(5'd0, 16'hBEEF);
    expect_val("R10 plain write", 0, 16'hBEEF);
    settle();
    wr(19, 16'h07FF);

    // R11 twin capture
    wr(16, 16'h0ABC);
    twin_trig = 1'b1;
    step(3);
    expect_val("R11 twin value", 18, 16'h0ABC);
    expect_val("R11 twin flag", 19, 16'h0400);
    expect_val("R11 irq_twin", SEL_TWIN, 16'h1);
    expect_val("R11 slot untouched", 2, 16'h3333);
    settle();
    wr(19, 16'h0400);
    wr(16, 16'h0DEF);
    twin_trig = 1'b0;
    step(3);
    expect_val("R11 fall ignored", 18, 16'h0ABC);
    expect_val("R11 no flag on fall", 19, 16'h0);
    settle();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule